// File: doc/BRIEF.md
# Three-Channel 16-Bit Timer Unit

The block holds three programmable up-counters of `CNT_W` bits. Channels 0 and 1 each own one input pin and one output pin. Channel 2 has no pins. Each channel counts when it is enabled and its selected source fires. The source is the core clock, a synchronized rising edge on the channel's pin, or the output pulse of channel 2, which then acts as a prescaler. On a pinned channel the input may instead be used as a gate, which allows counting only while it is high, or as a retrigger, where a rising edge restarts the count.

When a channel reaches its compare limit it wraps to zero and sets a sticky terminal-count flag. Its output then shows a one-clock low pulse in single-compare mode, or a level that alternates between two compare phases in dual-compare mode. A channel may run continuously or stop after one complete cycle. Channel 2's wrap pulse can also drive a one-clock DMA request.

Registers are reached through a flat write strobe with a combinational read.

Top module: `tmr_unit`

## Requirements
- R1: While reset is low and right after it, every count, compare and control register reads 0, `tmr_out` is 2'b11, and `tc_flag` and `dma_req` are 0.
- R2: `addr[3:2]` picks channel 0..2 (value 3 selects nothing: writes are dropped and reads return 0). `addr[1:0]` picks 0 control, 1 count, 2 compare A, 3 compare B. Control bits are: [0] enable, [1] continuous, [2] dual-compare, [4:3] source (0 clock, 1 pin edge, 2 channel-2 pulse), [6:5] input use (0 none, 1 gate, 2 retrigger), [7] terminal flag (read-only), [8] DMA enable. On channel 2, bits [6:2] are forced to 0.
- R3: With clock source, an enabled channel's count rises by one per clock. A step taken at the active limit (compare A, or compare B in the second dual phase) loads zero instead.
- R4: In single-compare mode the output is high, except for exactly one clock after each wrap, when it is low. With continuous mode the period is compare A + 1 clocks.
- R5: In dual-compare mode the output is high for compare A + 1 steps, then low for compare B + 1 steps, and then repeats. A control write restarts the sequence in the high phase.
- R6: With continuous clear, the enable bit clears on the wrap that ends the cycle (the first wrap when single, the compare-B wrap when dual). The count then stays 0 and the output stays high.
- R7: With pin-edge source, rising edges of the synchronized input are counted, with at most one counted edge in any 4 clocks. Slow edges are all counted; edges 2 clocks apart are counted every other one.
- R8: In gate mode, counting pauses while the synchronized input is low.
- R9: In retrigger mode, a synchronized rising edge on the input loads zero into the count.
- R10: A channel with source 2 takes one step per channel-2 wrap.
- R11: `dma_req` is high for one clock after each channel-2 wrap while its DMA enable is set, and stays low otherwise.
- R12: A wrap sets the channel's `tc_flag`. A write to that channel's control register clears it, and a wrap in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Channel and register select |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Combinational read data |
| tmr_in | input | 2 | Input pins of channels 0 and 1 |
| tmr_out | output | 2 | Output pins of channels 0 and 1 |
| tc_flag | output | 3 | Sticky terminal-count flags |
| dma_req | output | 1 | One-clock DMA request from channel 2 |

## Verification
The case hardest to reach from the ports is the edge-rate limit on the pin input. It shows up only when edges arrive closer together than the holdoff window, after passing through the synchronizer. The stimulus first sends widely spaced pulses to prove that none are lost. It then sends a burst of one-clock pulses two clocks apart, so that exactly half of them must be dropped. The prescaler chain is reached by running channel 2 with DMA enabled and counting both the request pulses and channel 0's steps over a fixed window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_PRE  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        USE_FREE   = 2'd0,
        USE_GATE   = 2'd1,
        USE_RETRIG = 2'd2,
        USE_RSV    = 2'd3
    } use_e;

    // bit 8 dma_en, bit 7 flag slot, [6:5] inuse, [4:3] src, [2] dual, [1] cont, [0] en
    typedef struct packed {
        logic dma_en;
        logic spare;
        use_e inuse;
        src_e src;
        logic dual;
        logic cont;
        logic en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam logic [1:0] R_CTRL  = 2'd0;
    localparam logic [1:0] R_COUNT = 2'd1;
    localparam logic [1:0] R_CMPA  = 2'd2;
    localparam logic [1:0] R_CMPB  = 2'd3;
endpackage

// File: rtl/tmr_insync.sv
module tmr_insync #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic step
);
    localparam int HW = (HOLD > 2) ? $clog2(HOLD) : 1;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          s3;
        logic [HW-1:0] hold;
    } sync_t;

    sync_t sync_q, sync_d;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
        lvl       = sync_q.s2;
        rise      = sync_q.s2 & ~sync_q.s3;
        step      = rise && (sync_q.hold == '0);
        if (step) begin
            sync_d.hold = HW'(HOLD - 1);
        end else if (sync_q.hold != '0) begin
            sync_d.hold = sync_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW      = 16,
    parameter bit HAS_PIN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_reg,
    input  logic [CW-1:0] wdata,
    input  logic          in_lvl,
    input  logic          in_rise,
    input  logic          in_step,
    input  logic          pre_step,
    output logic [CW-1:0] ctrl_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cmpa_o,
    output logic [CW-1:0] cmpb_o,
    output logic          flag_o,
    output logic          wrap_o,
    output logic          out_o
);
    typedef struct packed {
        cfg_t          cfg;
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmpa;
        logic [CW-1:0] cmpb;
        logic          phase;
        logic          pulse;
        logic          flag;
    } chan_t;

    chan_t         chan_q, chan_d;
    cfg_t          wcfg;
    logic          src_hit;
    logic          gate_ok;
    logic          retrig;
    logic          step;
    logic          wrap;
    logic [CW-1:0] limit;

    always_comb begin
        wcfg       = cfg_t'(wdata[CFG_W-1:0]);
        wcfg.spare = 1'b0;
        if (!HAS_PIN) begin
            wcfg.src   = SRC_CLK;
            wcfg.inuse = USE_FREE;
            wcfg.dual  = 1'b0;
        end
    end

    always_comb begin
        chan_d = chan_q;
        unique case (chan_q.cfg.src)
            SRC_CLK: src_hit = 1'b1;
            SRC_EXT: src_hit = in_step;
            SRC_PRE: src_hit = pre_step;
            default: src_hit = 1'b0;
        endcase
        gate_ok = (chan_q.cfg.inuse == USE_GATE) ? in_lvl : 1'b1;
        retrig  = chan_q.cfg.en && (chan_q.cfg.inuse == USE_RETRIG) && in_rise;
        limit   = chan_q.phase ? chan_q.cmpb : chan_q.cmpa;
        step    = chan_q.cfg.en && src_hit && gate_ok && !retrig;
        wrap    = step && (chan_q.cnt == limit);

        chan_d.pulse = wrap && !chan_q.cfg.dual;

        if (retrig) begin
            chan_d.cnt = '0;
        end else if (wrap) begin
            chan_d.cnt = '0;
            if (chan_q.cfg.dual) begin
                chan_d.phase = ~chan_q.phase;
            end
            if (!chan_q.cfg.cont && (!chan_q.cfg.dual || chan_q.phase)) begin
                chan_d.cfg.en = 1'b0;
            end
        end else if (step) begin
            chan_d.cnt = chan_q.cnt + 1'b1;
        end

        if (wr_en) begin
            unique case (wr_reg)
                R_CTRL: begin
                    chan_d.cfg   = wcfg;
                    chan_d.flag  = 1'b0;
                    chan_d.phase = 1'b0;
                end
                R_COUNT: chan_d.cnt  = wdata;
                R_CMPA:  chan_d.cmpa = wdata;
                default: chan_d.cmpb = wdata;
            endcase
        end

        // a wrap in the same cycle as a clearing write keeps the flag set
        if (wrap) begin
            chan_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else begin
            chan_q <= chan_d;
        end
    end

    always_comb begin
        ctrl_o          = '0;
        ctrl_o[CFG_W-1:0] = {chan_q.cfg.dma_en, chan_q.flag, chan_q.cfg[CFG_W-3:0]};
        cnt_o           = chan_q.cnt;
        cmpa_o          = chan_q.cmpa;
        cmpb_o          = chan_q.cmpb;
        flag_o          = chan_q.flag;
        wrap_o          = wrap;
        out_o           = chan_q.cfg.dual ? ~chan_q.phase : ~chan_q.pulse;
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int HOLD_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic [1:0]       tmr_in,
    output logic [1:0]       tmr_out,
    output logic [2:0]       tc_flag,
    output logic             dma_req
);
    localparam int NCH    = 3;
    localparam int NPIN   = 2;
    localparam int PRE_CH = NCH - 1;

    logic [NCH-1:0]   lvl_w, rise_w, step_w, wrap_w, out_w, flag_w, sel_w;
    logic [CNT_W-1:0] ctrl_w [NCH];
    logic [CNT_W-1:0] cnt_w  [NCH];
    logic [CNT_W-1:0] cmpa_w [NCH];
    logic [CNT_W-1:0] cmpb_w [NCH];
    logic             pre_step;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_in
            if (i < NPIN) begin : g_pin
                tmr_insync #(.HOLD(HOLD_CLKS)) u_sync (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .pin  (tmr_in[i]),
                    .lvl  (lvl_w[i]),
                    .rise (rise_w[i]),
                    .step (step_w[i])
                );
            end else begin : g_nopin
                assign lvl_w[i]  = 1'b0;
                assign rise_w[i] = 1'b0;
                assign step_w[i] = 1'b0;
            end
        end

        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign sel_w[i] = wr_en && (addr[3:2] == 2'(i));
            tmr_chan #(.CW(CNT_W), .HAS_PIN(1'(i < NPIN))) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (sel_w[i]),
                .wr_reg  (addr[1:0]),
                .wdata   (wdata),
                .in_lvl  (lvl_w[i]),
                .in_rise (rise_w[i]),
                .in_step (step_w[i]),
                .pre_step(pre_step),
                .ctrl_o  (ctrl_w[i]),
                .cnt_o   (cnt_w[i]),
                .cmpa_o  (cmpa_w[i]),
                .cmpb_o  (cmpb_w[i]),
                .flag_o  (flag_w[i]),
                .wrap_o  (wrap_w[i]),
                .out_o   (out_w[i])
            );
        end
    endgenerate

    // channel 2 is single-compare only, so its low output is its wrap pulse
    assign pre_step = ~out_w[PRE_CH];
    assign dma_req  = ~out_w[PRE_CH] & ctrl_w[PRE_CH][CFG_W-1];
    assign tmr_out  = out_w[NPIN-1:0];
    assign tc_flag  = flag_w;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr[3:2] == 2'(i)) begin
                unique case (addr[1:0])
                    R_CTRL:  rdata = ctrl_w[i];
                    R_COUNT: rdata = cnt_w[i];
                    R_CMPA:  rdata = cmpa_w[i];
                    default: rdata = cmpb_w[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    tmr_out,
    input logic [2:0]    tc_flag,
    input logic          dma_req,
    input logic [2:0]    wrap_w,
    input logic [2:0]    step_w,
    input logic [CW-1:0] ctrl_w [3]
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (tc_flag == 3'b000 && tmr_out == 2'b11 && !dma_req)
                else $error("reset outputs wrong");
        end
    end

    generate
        for (genvar i = 0; i < 3; i++) begin : g_all
            p_flag_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
                wrap_w[i] |=> tc_flag[i])
                else $error("flag not set after wrap");
        end

        for (genvar i = 0; i < 2; i++) begin : g_pin
            p_edge_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
                step_w[i] |-> (!$past(step_w[i]) && !$past(step_w[i], 2) && !$past(step_w[i], 3)))
                else $error("pin edges counted too close");

            p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctrl_w[i][2] && !tmr_out[i]) |-> $past(wrap_w[i]))
                else $error("single-mode low without wrap");

            p_dual_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_w[i][2] && !$past(wrap_w[i]) && !$past(wr_en)) |-> $stable(tmr_out[i]))
                else $error("dual-mode level moved without wrap");
        end
    endgenerate

    p_dma_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(wrap_w[2]))
        else $error("dma request without channel 2 wrap");
endmodule

bind tmr_unit tmr_chk #(.CW(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .tmr_out(tmr_out),
    .tc_flag(tc_flag),
    .dma_req(dma_req),
    .wrap_w (wrap_w),
    .step_w (step_w),
    .ctrl_w (ctrl_w)
);

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  tmr_in = 2'b00;
    logic [1:0]  tmr_out;
    logic [2:0]  tc_flag;
    logic        dma_req;

    int n_run = 0;
    int n_fail = 0;

    tmr_unit u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .tmr_in (tmr_in),
        .tmr_out(tmr_out),
        .tc_flag(tc_flag),
        .dma_req(dma_req)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic t_reset();
        int v;
        for (int c = 0; c < 3; c++) begin
            rd(4'(c * 4), v);
            chk("R1 ctrl after reset", v, 0);
            rd(4'(c * 4 + 1), v);
            chk("R1 count after reset", v, 0);
        end
        chk("R1 outputs after reset", int'(tmr_out), 3);
        chk("R1 flags after reset", int'(tc_flag), 0);
        chk("R1 dma after reset", int'(dma_req), 0);
    endtask

    task automatic t_regs();
        int v;
        wr(4'h6, 16'h1234);
        rd(4'h6, v);
        chk("R2 cmp A readback", v, 16'h1234);
        wr(4'h7, 16'hBEEF);
        rd(4'h7, v);
        chk("R2 cmp B readback", v, 16'hBEEF);
        wr(4'h8, 16'h01FF);
        rd(4'h8, v);
        chk("R2 channel 2 forced fields", v, 16'h0103);
        wr(4'h8, 16'h0000);
        wr(4'hC, 16'hFFFF);
        rd(4'hC, v);
        chk("R2 unused select reads 0", v, 0);
        rd(4'h0, v);
        chk("R2 unused select no write", v, 0);
    endtask

    task automatic t_count();
        int v;
        wr(4'h2, 16'd100);
        wr(4'h1, 16'd0);
        wr(4'h0, 16'h0003);
        ticks(10);
        rd(4'h1, v);
        chk("R3 count by clock", v, 10);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_single();
        int lows = 0;
        int pairs = 0;
        logic prev = 1'b1;
        wr(4'h2, 16'd4);
        wr(4'h1, 16'd0);
        wr(4'h0, 16'h0003);
        for (int k = 1; k <= 20; k++) begin
            ticks(1);
            if (!tmr_out[0]) lows++;
            if (!tmr_out[0] && !prev) pairs++;
            prev = tmr_out[0];
        end
        chk("R4 single pulses in 20 clocks", lows, 4);
        chk("R4 pulses one clock wide", pairs, 0);
        chk("R12 flag set on wrap", int'(tc_flag[0]), 1);
        wr(4'h0, 16'h0000);
        chk("R12 flag cleared by ctrl write", int'(tc_flag[0]), 0);
    endtask

    task automatic t_dual();
        int bad = 0;
        wr(4'h6, 16'd3);
        wr(4'h7, 16'd1);
        wr(4'h5, 16'd0);
        wr(4'h4, 16'h0007);
        for (int k = 1; k <= 12; k++) begin
            ticks(1);
            if (tmr_out[1] != ((k % 6) < 4)) bad++;
        end
        chk("R5 dual waveform mismatches", bad, 0);
        wr(4'h4, 16'h0000);
        chk("R5 output high after ctrl write", int'(tmr_out[1]), 1);
    endtask

    task automatic t_oneshot();
        int v;
        wr(4'h2, 16'd2);
        wr(4'h1, 16'd0);
        wr(4'h0, 16'h0001);
        ticks(10);
        rd(4'h1, v);
        chk("R6 count held at 0", v, 0);
        rd(4'h0, v);
        chk("R6 enable cleared, flag set", v, 16'h0080);
        chk("R6 output high after shot", int'(tmr_out[0]), 1);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_ext();
        int v;
        wr(4'h2, 16'hFFFF);
        wr(4'h1, 16'd0);
        wr(4'h0, 16'h000B);
        for (int p = 0; p < 5; p++) begin
            tmr_in[0] = 1'b1;
            ticks(4);
            tmr_in[0] = 1'b0;
            ticks(4);
        end
        ticks(6);
        rd(4'h1, v);
        chk("R7 slow edges all counted", v, 5);
        for (int p = 0; p < 8; p++) begin
            tmr_in[0] = 1'b1;
            ticks(1);
            tmr_in[0] = 1'b0;
            ticks(1);
        end
        ticks(6);
        rd(4'h1, v);
        chk("R7 fast edges rate limited", v, 9);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_gate();
        int v;
        tmr_in[0] = 1'b0;
        ticks(4);
        wr(4'h1, 16'd0);
        wr(4'h0, 16'h0023);
        ticks(10);
        rd(4'h1, v);
        chk("R8 gate low holds count", v, 0);
        tmr_in[0] = 1'b1;
        ticks(10);
        rd(4'h1, v);
        chk("R8 gate high counts", v, 8);
        tmr_in[0] = 1'b0;
        ticks(10);
        rd(4'h1, v);
        chk("R8 gate closed again", v, 10);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_retrig();
        int v;
        tmr_in[1] = 1'b0;
        wr(4'h6, 16'd1000);
        wr(4'h5, 16'd0);
        wr(4'h4, 16'h0043);
        ticks(20);
        rd(4'h5, v);
        chk("R9 free count before edge", v, 20);
        tmr_in[1] = 1'b1;
        ticks(2);
        tmr_in[1] = 1'b0;
        ticks(8);
        rd(4'h5, v);
        chk("R9 count restarted by edge", v, 7);
        wr(4'h4, 16'h0000);
    endtask

    task automatic t_pre();
        int v;
        int pulses = 0;
        wr(4'h1, 16'd0);
        wr(4'h2, 16'hFFFF);
        wr(4'h0, 16'h0013);
        wr(4'h9, 16'd0);
        wr(4'hA, 16'd3);
        wr(4'h8, 16'h0103);
        for (int k = 1; k <= 40; k++) begin
            ticks(1);
            if (dma_req) pulses++;
        end
        chk("R11 dma pulses per wrap", pulses, 10);
        rd(4'h1, v);
        chk("R10 prescaled count", v, 9);
        wr(4'h8, 16'h0003);
        pulses = 0;
        for (int k = 1; k <= 20; k++) begin
            ticks(1);
            if (dma_req) pulses++;
        end
        chk("R11 no dma when disabled", pulses, 0);
        chk("R12 channel 2 flag set", int'(tc_flag[2]), 1);
        wr(4'hA, 16'd1000);
        wr(4'h8, 16'h0000);
        ticks(8);
        chk("R12 channel 2 flag cleared", int'(tc_flag[2]), 0);
        wr(4'h0, 16'h0000);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        ticks(3);
        t_reset();
        rst_n = 1'b1;
        ticks(2);
        t_reset();
        t_regs();
        t_count();
        t_single();
        t_dual();
        t_oneshot();
        t_ext();
        t_gate();
        t_retrig();
        t_pre();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule